// File: doc/BRIEF.md
# Sub-word Register Reservation Tracker

This block keeps the in-use reservations of a large set of 64-bit registers at sub-word granularity. Each register is seen as eight byte lanes. An issuing stage asks to reserve one portion of one register: a single byte, a 16-bit pair, a 32-bit half or the full 64-bit word. The block grants the request only when none of the lanes that the portion covers is already held by an earlier reservation on that same register, and then records it. When the producing operation writes back, a release names the register and portion again and frees those lanes.

Locks therefore cascade across widths on their own. A held byte blocks the 16-, 32- and 64-bit portions that contain it, but leaves its sibling bytes and the other 16-bit portions free. A held full word blocks every smaller portion of that register. Portions that do not sit on their natural boundary are refused. A registered lookup port returns the byte-busy mask of any register, so that a scheduler or a debug view can see which lanes are taken.

Top module: `byte_hazard_tracker`

## Requirements
- R1: After synchronous active-high reset, every register's busy mask is zero and `rsp_valid` is low.
- R2: A valid, aligned request whose lanes are all free is answered one cycle later with `rsp_valid`=1 and `rsp_grant`=1, and its lanes become busy. Width codes: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits. The position is the lowest byte index covered, and byte i is bit i of a busy mask.
- R3: A valid, aligned request that overlaps any busy lane of its register is answered with `rsp_conflict`=1 and leaves all busy masks unchanged.
- R4: Holding byte 0 still lets byte 1 and the 16-bit portions at positions 2, 4 and 6 be granted, while the 16-bit portion at 0, the 32-bit portion at 0 and the 64-bit portion conflict.
- R5: Holding the full 64-bit word makes every 8-, 16- and 32-bit request on that register conflict.
- R6: Holding a 32-bit portion makes the 16- and 8-bit portions inside it conflict, while those of the other 32-bit half are granted.
- R7: A 16-bit request at an odd position, a 32-bit request at a position other than 0 or 4, or a 64-bit request at a position other than 0 is answered with `rsp_misalign`=1 and changes no busy mask.
- R8: A valid, aligned release clears the lanes of its portion on its register at the next clock edge. A misaligned release has no effect.
- R9: When a release and a request name the same register in the same cycle, the release is applied first, so the request can be granted on the lanes being freed.
- R10: Reservations on one register never affect requests or masks of any other register, including the highest-numbered one.
- R11: The lookup port returns, one cycle after `query_reg` is presented, the busy mask that register held before that clock edge.
- R12: Exactly one of `rsp_grant`, `rsp_conflict` and `rsp_misalign` is high in a cycle where `rsp_valid` is high, and none when it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Reservation request present |
| req_reg | input | REG_W | Register named by the request |
| req_width | input | 2 | Portion width code of the request |
| req_pos | input | 3 | Lowest byte index of the requested portion |
| rel_valid | input | 1 | Release present |
| rel_reg | input | REG_W | Register named by the release |
| rel_width | input | 2 | Portion width code of the release |
| rel_pos | input | 3 | Lowest byte index of the released portion |
| rsp_valid | output | 1 | Registered response to last cycle's request |
| rsp_grant | output | 1 | Request was granted and recorded |
| rsp_conflict | output | 1 | Request overlapped a busy lane |
| rsp_misalign | output | 1 | Request portion was not on its boundary |
| query_reg | input | REG_W | Register whose busy mask is looked up |
| query_mask | output | 8 | Registered busy mask of the looked-up register |

## Verification
On every cycle the assertions check that a response carries exactly one outcome, that a decoded portion covers the number of lanes its width implies, that a granted portion is busy afterwards and never overlapped live lanes when it was granted, and that a release clears its lanes. Only the bench's scenarios show the cascade itself: which sibling portions stay free beside a held byte or half, that misaligned requests and releases leave masks alone, that a release in the same cycle frees lanes for a request, and that registers stay independent, all compared against a reference model over random traffic.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  localparam int LANES = 8;
  localparam int POS_W = $clog2(LANES);

  typedef enum logic [1:0] {
    PW_BYTE  = 2'd0,
    PW_HALF  = 2'd1,
    PW_WORD  = 2'd2,
    PW_DWORD = 2'd3
  } part_w_e;

  typedef logic [LANES-1:0] lane_mask_t;

endpackage

// File: rtl/hzd_portion_decode.sv
module hzd_portion_decode
  import hzd_pkg::*;
(
  input  logic [1:0]       width,
  input  logic [POS_W-1:0] pos,
  output lane_mask_t       mask,
  output logic             misalign
);

  part_w_e w;
  assign w = part_w_e'(width);

  always_comb begin
    mask     = '0;
    misalign = 1'b0;
    unique case (w)
      PW_BYTE: begin
        mask = lane_mask_t'(8'h01) << pos;
      end
      PW_HALF: begin
        misalign = pos[0];
        mask     = lane_mask_t'(8'h03) << pos;
      end
      PW_WORD: begin
        misalign = (pos[1:0] != 2'd0);
        mask     = lane_mask_t'(8'h0F) << pos;
      end
      PW_DWORD: begin
        misalign = (pos != '0);
        mask     = lane_mask_t'(8'hFF);
      end
      default: begin
        mask     = '0;
        misalign = 1'b1;
      end
    endcase
    if (misalign) mask = '0;
  end

  // R7: an aligned portion covers exactly 1, 2, 4 or 8 lanes
  always_comb begin
    if (!misalign) begin
      p_lane_count_r7: assert ($countones(mask) == (1 << width));
    end
  end

endmodule

// File: rtl/hzd_busy_store.sv
module hzd_busy_store
  import hzd_pkg::*;
#(
  parameter int NUM_REGS = 256,
  localparam int REG_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
)(
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] rd_reg,
  output lane_mask_t       rd_mask,
  input  logic             upd_en,
  input  logic [REG_W-1:0] upd_reg,
  input  lane_mask_t       upd_mask,
  input  logic             clr_en,
  input  logic [REG_W-1:0] clr_reg,
  input  lane_mask_t       clr_mask,
  input  logic [REG_W-1:0] query_reg,
  output lane_mask_t       query_mask
);

  lane_mask_t busy_q [NUM_REGS];

  assign rd_mask = busy_q[rd_reg];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    lane_mask_t clr_here;
    lane_mask_t set_here;
    assign clr_here = (clr_en && clr_reg == REG_W'(g)) ? clr_mask : '0;
    assign set_here = (upd_en && upd_reg == REG_W'(g)) ? upd_mask : '0;
    always_ff @(posedge clk) begin
      if (rst) busy_q[g] <= '0;
      else     busy_q[g] <= (busy_q[g] & ~clr_here) | set_here;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) query_mask <= '0;
    else     query_mask <= busy_q[query_reg];
  end

  // R2: granted lanes are busy after the edge
  p_grant_recorded_r2: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> ((busy_q[$past(upd_reg)] & $past(upd_mask)) == $past(upd_mask)));

  // R8: released lanes are free after the edge unless regranted
  p_release_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !(upd_en && upd_reg == clr_reg))
      |=> ((busy_q[$past(clr_reg)] & $past(clr_mask)) == '0));

  // R3/R9: a grant never lands on lanes still busy after this cycle's release
  p_no_overlap_r3: assert property (@(posedge clk) disable iff (rst)
    upd_en |-> (((busy_q[upd_reg] &
                 ~((clr_en && clr_reg == upd_reg) ? clr_mask : '0)) & upd_mask) == '0));

endmodule

// File: rtl/byte_hazard_tracker.sv
module byte_hazard_tracker
  import hzd_pkg::*;
#(
  parameter int NUM_REGS = 256,
  localparam int REG_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [REG_W-1:0] req_reg,
  input  logic [1:0]       req_width,
  input  logic [2:0]       req_pos,
  input  logic             rel_valid,
  input  logic [REG_W-1:0] rel_reg,
  input  logic [1:0]       rel_width,
  input  logic [2:0]       rel_pos,
  output logic             rsp_valid,
  output logic             rsp_grant,
  output logic             rsp_conflict,
  output logic             rsp_misalign,
  input  logic [REG_W-1:0] query_reg,
  output logic [7:0]       query_mask
);

  lane_mask_t req_mask, rel_mask, live_mask, after_rel;
  logic       req_mis, rel_mis, rel_en, overlap, grant_now;
  lane_mask_t q_mask;

  hzd_portion_decode u_req_dec (
    .width    (req_width),
    .pos      (req_pos),
    .mask     (req_mask),
    .misalign (req_mis)
  );

  hzd_portion_decode u_rel_dec (
    .width    (rel_width),
    .pos      (rel_pos),
    .mask     (rel_mask),
    .misalign (rel_mis)
  );

  assign rel_en = rel_valid && !rel_mis;

  // release takes effect before the request is judged
  assign after_rel = (rel_en && rel_reg == req_reg) ? (live_mask & ~rel_mask) : live_mask;
  assign overlap   = |(after_rel & req_mask);
  assign grant_now = req_valid && !req_mis && !overlap;

  hzd_busy_store #(.NUM_REGS(NUM_REGS)) u_store (
    .clk        (clk),
    .rst        (rst),
    .rd_reg     (req_reg),
    .rd_mask    (live_mask),
    .upd_en     (grant_now),
    .upd_reg    (req_reg),
    .upd_mask   (req_mask),
    .clr_en     (rel_en),
    .clr_reg    (rel_reg),
    .clr_mask   (rel_mask),
    .query_reg  (query_reg),
    .query_mask (q_mask)
  );

  assign query_mask = q_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_grant    <= 1'b0;
      rsp_conflict <= 1'b0;
      rsp_misalign <= 1'b0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_grant    <= grant_now;
      rsp_conflict <= req_valid && !req_mis && overlap;
      rsp_misalign <= req_valid && req_mis;
    end
  end

  // R12: exactly one outcome per response
  p_one_outcome_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $onehot({rsp_grant, rsp_conflict, rsp_misalign}));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_grant || rsp_conflict || rsp_misalign));

  // R1: reset leaves no response pending
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> !rsp_valid);

endmodule

// File: tb/sim_byte_hazard_tracker.sv
module sim_byte_hazard_tracker;

  localparam int NUM_REGS = 256;
  localparam int REG_W = $clog2(NUM_REGS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, rel_valid = 1'b0;
  logic [REG_W-1:0] req_reg = '0, rel_reg = '0, query_reg = '0;
  logic [1:0] req_width = '0, rel_width = '0;
  logic [2:0] req_pos = '0, rel_pos = '0;
  logic rsp_valid, rsp_grant, rsp_conflict, rsp_misalign;
  logic [7:0] query_mask;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model [NUM_REGS];

  always #10 clk = ~clk;

  byte_hazard_tracker #(.NUM_REGS(NUM_REGS)) u0 (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_reg(req_reg), .req_width(req_width), .req_pos(req_pos),
    .rel_valid(rel_valid), .rel_reg(rel_reg), .rel_width(rel_width), .rel_pos(rel_pos),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_conflict(rsp_conflict),
    .rsp_misalign(rsp_misalign), .query_reg(query_reg), .query_mask(query_mask)
  );

  function automatic bit f_mis(input logic [1:0] w, input logic [2:0] p);
    case (w)
      2'd0: return 1'b0;
      2'd1: return p[0];
      2'd2: return p[1:0] != 0;
      default: return p != 0;
    endcase
  endfunction

  function automatic logic [7:0] f_mask(input logic [1:0] w, input logic [2:0] p);
    logic [7:0] span;
    span = (w == 2'd0) ? 8'h01 : (w == 2'd1) ? 8'h03 : (w == 2'd2) ? 8'h0F : 8'hFF;
    return span << p;
  endfunction

  // outcome codes: 0 grant, 1 conflict, 2 misalign, 3 none
  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // want < 0: expected outcome from model
  task automatic op(input logic [REG_W-1:0] r, input logic [1:0] w, input logic [2:0] p,
                    input bit rv, input logic [REG_W-1:0] rr, input logic [1:0] rw,
                    input logic [2:0] rp, input int want, input string tag);
    int exp, act;
    logic [7:0] cur;
    @(negedge clk);
    req_valid = 1'b1; req_reg = r; req_width = w; req_pos = p;
    rel_valid = rv;   rel_reg = rr; rel_width = rw; rel_pos = rp;
    cur = model[r];
    if (rv && !f_mis(rw, rp) && rr == r) cur = cur & ~f_mask(rw, rp);
    if (f_mis(w, p)) exp = 2;
    else if ((cur & f_mask(w, p)) != 0) exp = 1;
    else exp = 0;
    if (want >= 0 && want != exp) begin
      checks++; errors++;
      $display("FAIL %s model disagrees actual=%0d expected=%0d", tag, exp, want);
    end
    if (rv && !f_mis(rw, rp)) model[rr] = model[rr] & ~f_mask(rw, rp);
    if (exp == 0) model[r] = model[r] | f_mask(w, p);
    @(posedge clk); #1;
    act = !rsp_valid ? 3 : (rsp_grant + rsp_conflict + rsp_misalign != 1) ? 4 :
          rsp_grant ? 0 : rsp_conflict ? 1 : 2;
    check(tag, act, exp);
    req_valid = 1'b0; rel_valid = 1'b0;
  endtask

  task automatic rel(input logic [REG_W-1:0] rr, input logic [1:0] rw, input logic [2:0] rp);
    @(negedge clk);
    req_valid = 1'b0;
    rel_valid = 1'b1; rel_reg = rr; rel_width = rw; rel_pos = rp;
    if (!f_mis(rw, rp)) model[rr] = model[rr] & ~f_mask(rw, rp);
    @(posedge clk); #1;
    rel_valid = 1'b0;
  endtask

  task automatic query(input logic [REG_W-1:0] r, input string tag);
    @(negedge clk);
    req_valid = 1'b0; rel_valid = 1'b0; query_reg = r;
    @(posedge clk); #1;
    check(tag, int'(query_mask), int'(model[r]));
  endtask

  task automatic clear_all();
    for (int i = 0; i < 8; i++) rel(REG_W'(i), 2'd3, 3'd0);
    rel(REG_W'(NUM_REGS-1), 2'd3, 3'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < NUM_REGS; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    check("R1 rsp_valid after reset", int'(rsp_valid), 0);
    query(REG_W'(0), "R1 mask reg0 after reset");
    query(REG_W'(NUM_REGS-1), "R1 mask top reg after reset");

    // R2 basic grant and recording
    op(1, 2'd1, 3'd2, 0, 0, 0, 0, 0, "R2 grant half at 2");
    query(1, "R2 mask holds bytes 2,3");
    // R3 overlap
    op(1, 2'd0, 3'd3, 0, 0, 0, 0, 1, "R3 byte 3 overlaps");
    query(1, "R3 mask unchanged");

    // R4 cascade from byte 0
    op(5, 2'd0, 3'd0, 0, 0, 0, 0, 0, "R4 byte0");
    op(5, 2'd0, 3'd1, 0, 0, 0, 0, 0, "R4 byte1 free");
    op(5, 2'd1, 3'd2, 0, 0, 0, 0, 0, "R4 half at 2 free");
    op(5, 2'd1, 3'd4, 0, 0, 0, 0, 0, "R4 half at 4 free");
    op(5, 2'd1, 3'd6, 0, 0, 0, 0, 0, "R4 half at 6 free");
    op(5, 2'd1, 3'd0, 0, 0, 0, 0, 1, "R4 half at 0 blocked");
    op(5, 2'd2, 3'd0, 0, 0, 0, 0, 1, "R4 word at 0 blocked");
    op(5, 2'd3, 3'd0, 0, 0, 0, 0, 1, "R4 dword blocked");

    // R5 full word blocks everything
    op(6, 2'd3, 3'd0, 0, 0, 0, 0, 0, "R5 dword");
    op(6, 2'd0, 3'd7, 0, 0, 0, 0, 1, "R5 byte7 blocked");
    op(6, 2'd1, 3'd4, 0, 0, 0, 0, 1, "R5 half blocked");
    op(6, 2'd2, 3'd4, 0, 0, 0, 0, 1, "R5 word blocked");

    // R6 32-bit portion
    op(7, 2'd2, 3'd4, 0, 0, 0, 0, 0, "R6 upper word");
    op(7, 2'd1, 3'd6, 0, 0, 0, 0, 1, "R6 half inside blocked");
    op(7, 2'd0, 3'd5, 0, 0, 0, 0, 1, "R6 byte inside blocked");
    op(7, 2'd1, 3'd2, 0, 0, 0, 0, 0, "R6 half in other word free");
    op(7, 2'd0, 3'd0, 0, 0, 0, 0, 0, "R6 byte in other word free");

    // R7 misaligned
    op(2, 2'd1, 3'd3, 0, 0, 0, 0, 2, "R7 half at odd");
    op(2, 2'd2, 3'd2, 0, 0, 0, 0, 2, "R7 word at 2");
    op(2, 2'd3, 3'd4, 0, 0, 0, 0, 2, "R7 dword at 4");
    query(2, "R7 mask untouched");

    // R8 release and misaligned release
    rel(7, 2'd2, 3'd5);
    query(7, "R8 misaligned release ignored");
    rel(7, 2'd2, 3'd4);
    query(7, "R8 release clears word");

    // R9 same-cycle release before grant
    op(6, 2'd2, 3'd0, 1, 6, 2'd3, 3'd0, 0, "R9 release then grant same cycle");
    query(6, "R9 mask after combined cycle");

    // R10 top register independent
    op(NUM_REGS-1, 2'd3, 3'd0, 0, 0, 0, 0, 0, "R10 top reg dword");
    op(NUM_REGS-2, 2'd3, 3'd0, 0, 0, 0, 0, 0, "R10 neighbour free");
    query(NUM_REGS-1, "R10 top mask");
    rel(NUM_REGS-2, 2'd3, 3'd0);

    clear_all();
    for (int i = 0; i < 8; i++) query(REG_W'(i), "R8 cleared");

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [REG_W-1:0] r, rr;
      r  = ($urandom_range(0, 9) == 0) ? REG_W'(NUM_REGS-1) : REG_W'($urandom_range(0, 3));
      rr = ($urandom_range(0, 1) == 0) ? r : REG_W'($urandom_range(0, 3));
      op(r, 2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)),
         ($urandom_range(0, 2) != 0), rr, 2'($urandom_range(0, 3)),
         3'($urandom_range(0, 7)), -1, "R2/R3/R7/R9 random");
      if ((n % 16) == 0) query(r, "R11 random query");
    end
    for (int i = 0; i < 4; i++) query(REG_W'(i), "R11 final mask");
    query(REG_W'(NUM_REGS-1), "R10 final top mask");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule